// File: doc/BRIEF.md
# I2S Slave Audio Receiver

This block turns an incoming two-channel serial audio stream into parallel samples. It acts as a bus slave. The bit clock, the channel-select line and the serial data all come from an external master. The block brings the three lines into the system clock domain and finds each rising edge of the bit clock there. On every such edge it takes one data bit.

A change of the channel-select line ends the word that is in progress. The serial bit taken on that same edge is the last bit of the finished word. The next bit is the most significant bit of the following word. Each finished word is placed MSB-first into a register whose width is a parameter. If the transmitter sends more bits than this width, the extra low-order bits are dropped. If it sends fewer, the missing low-order bits are zero. No word length has to be configured.

Each finished word leaves the block with a one-cycle valid pulse and a channel flag. The first, partial word after reset is never delivered.

Top module: `i2s_slave_rx`

## Requirements
- R1: While reset is asserted and until the first word is delivered, `sample_valid`, `sample_data` and `sample_right` are all 0.
- R2: Serial data is taken only on rising edges of the bit clock. The first bit after a channel-select change goes to bit SAMPLE_W-1 of the word, and each later bit goes to the next lower position.
- R3: `sample_right` is 0 for a word sent while the channel-select line was low (left) and 1 for a word sent while it was high (right). Consecutive delivered words therefore carry opposite channel flags.
- R4: When a word has more than SAMPLE_W bits, only its first SAMPLE_W bits are kept and the later bits have no effect on the output.
- R5: When a word has fewer than SAMPLE_W bits, it stays left-aligned and every bit position below its last bit reads 0.
- R6: Each completed word produces exactly one `sample_valid` pulse, one system clock wide. `sample_data` and `sample_right` change only in a cycle where `sample_valid` is high.
- R7: The word that is in progress when reset is released is discarded. Nothing is delivered until the channel-select line has changed at least twice after reset, and the first word delivered is the one that begins after the first change.
- R8: A word of exactly SAMPLE_W bits is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least four times the bit clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| i2s_sck | input | 1 | Serial bit clock from the master (asynchronous) |
| i2s_ws | input | 1 | Channel select: 0 = left, 1 = right (asynchronous) |
| i2s_sd | input | 1 | Serial data, MSB first, two's complement (asynchronous) |
| sample_data | output | SAMPLE_W | Last completed word, left-aligned |
| sample_valid | output | 1 | One-cycle pulse when `sample_data` holds a new word |
| sample_right | output | 1 | Channel of the delivered word: 1 = right, 0 = left |

## Verification
The assertions assume that the bit clock is slow enough for at least two system cycles to separate successive valid pulses. They also assume that the channel-select line changes only while the bit clock is low, so that each change is seen on exactly one rising edge.

The stimulus keeps both conditions. It holds each bit-clock phase for four system cycles, and it updates channel select and data together on the falling edge. It always alternates channels, as a real master does.

Word lengths are random between 1 and 28 bits, around a 16-bit receiver. Directed cases cover the exact width, a single-bit word, a 32-bit word and a discarded partial word at start-up.

// File: rtl/i2srx_pkg.sv
// Package: shared types for the I2S slave receiver.
// Assumes nothing beyond IEEE 1800-2017 type support.
package i2srx_pkg;

    // Framing progress of the deserializer after reset.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no channel-select level recorded yet
        ST_HUNT = 2'd1,   // level known, waiting for the first change
        ST_RUN  = 2'd2    // aligned to word boundaries, delivering words
    } rx_state_t;

    // Channel encoding as carried by the select line.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_t;

endpackage

// File: rtl/i2srx_sync.sv
// Module: multi-bit synchroniser, one flop chain per bit.
// Assumes each bit is independent and may be sampled a cycle late;
// STAGES must be at least 2 for metastability settling.
module i2srx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/i2srx_edge.sv
// Module: rising-edge detector for a signal already in the clk domain.
// Assumes the input stays at each level for at least two clk cycles.
module i2srx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_stb
);

    logic level_q;

    // Remember the previous level so that a 0->1 step can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise_stb = level_in & ~level_q;

endmodule

// File: rtl/i2srx_deser.sv
// Module: word framing and MSB-aligned capture.
// On each bit strobe it takes one data bit. A change of channel select
// closes the current word: the bit taken on that strobe is the word's
// last bit. Bits past SAMPLE_W are dropped and unfilled bits stay zero.
// Assumes bit_stb is a single-cycle pulse and SAMPLE_W >= 2.
module i2srx_deser
    import i2srx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_stb,
    input  logic                ws_bit,
    input  logic                sd_bit,
    output logic [SAMPLE_W-1:0] word_out,
    output logic                word_valid,
    output logic                word_right
);

    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0]    CNT_FULL = CNT_W'(SAMPLE_W);
    localparam logic [SAMPLE_W-1:0] TOP_ONE  = {1'b1, {(SAMPLE_W-1){1'b0}}};

    rx_state_t           state_q;
    chan_t               chan_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] acc_q;
    logic [SAMPLE_W-1:0] slot_mask;
    logic [SAMPLE_W-1:0] acc_next;
    logic                ws_change;

    // Mask for the next free bit position; it is zero once the word is full.
    always_comb begin
        slot_mask = TOP_ONE >> cnt_q;
        acc_next  = acc_q | (sd_bit ? slot_mask : '0);
        ws_change = (ws_bit != chan_q);
    end

    // Framing state, channel tracking and bit accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= CH_LEFT;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else if (bit_stb) begin
            unique case (state_q)
                ST_IDLE: begin
                    chan_q  <= chan_t'(ws_bit);
                    state_q <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (ws_change) begin
                        chan_q  <= chan_t'(ws_bit);
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        acc_q   <= '0;
                    end
                end
                default: begin
                    if (ws_change) begin
                        chan_q <= chan_t'(ws_bit);
                        cnt_q  <= '0;
                        acc_q  <= '0;
                    end else begin
                        acc_q <= acc_next;
                        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Deliver the finished word with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            word_right <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (bit_stb && state_q == ST_RUN && ws_change) begin
                word_out   <= acc_next;
                word_right <= (chan_q == CH_RIGHT);
                word_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2s_slave_rx.sv
// Module: I2S slave receiver top.
// It synchronises bit clock, channel select and data together, finds
// rising bit-clock edges and passes each sampled bit to the deserializer.
// Assumes clk is at least 4x the bit clock, and that select and data
// change only while the bit clock is low.
module i2s_slave_rx #(
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i2s_sck,
    input  logic                i2s_ws,
    input  logic                i2s_sd,
    output logic [SAMPLE_W-1:0] sample_data,
    output logic                sample_valid,
    output logic                sample_right
);

    logic [2:0] pins_sync;
    logic       sck_rise;

    // All three lines share one chain, so they stay aligned to each other.
    i2srx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({i2s_sck, i2s_ws, i2s_sd}),
        .sync_out (pins_sync)
    );

    i2srx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (pins_sync[2]),
        .rise_stb (sck_rise)
    );

    i2srx_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (sck_rise),
        .ws_bit     (pins_sync[1]),
        .sd_bit     (pins_sync[0]),
        .word_out   (sample_data),
        .word_valid (sample_valid),
        .word_right (sample_right)
    );

endmodule

// File: rtl/i2s_slave_rx_chk.sv
// Module: assertion checker for i2s_slave_rx, attached through bind.
// Assumes the bit clock is at most a quarter of the clk rate.
module i2s_slave_rx_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                i2s_ws,
    input logic [SAMPLE_W-1:0] sample_data,
    input logic                sample_valid,
    input logic                sample_right
);

    logic       ws_prev_q;
    logic       ws_primed_q;
    logic [1:0] ws_changes_q;
    logic       last_right_q;
    logic       have_word_q;

    // Count raw channel-select changes since reset, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev_q    <= 1'b0;
            ws_primed_q  <= 1'b0;
            ws_changes_q <= '0;
        end else begin
            ws_prev_q   <= i2s_ws;
            ws_primed_q <= 1'b1;
            if (ws_primed_q && i2s_ws != ws_prev_q && ws_changes_q != 2'd2)
                ws_changes_q <= ws_changes_q + 2'd1;
        end
    end

    // Remember the channel of the last delivered word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_right_q <= 1'b0;
            have_word_q  <= 1'b0;
        end else if (sample_valid) begin
            last_right_q <= sample_right;
            have_word_q  <= 1'b1;
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sample_data) || !$stable(sample_right)) |-> sample_valid);

    // R3
    chan_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && have_word_q) |-> (sample_right != last_right_q));

    // R7
    discard_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (ws_changes_q == 2'd2));

endmodule

bind i2s_slave_rx i2s_slave_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .i2s_ws       (i2s_ws),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .sample_right (sample_right)
);

// File: tb/i2s_slave_rx_tb.sv
// Bench: drives an I2S master model and checks the delivered words
// against values computed from the requirements.
module i2s_slave_rx_tb;

    localparam int W    = 16;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         ws = 1'b1;
    logic         sd = 1'b0;
    logic [W-1:0] sample_data;
    logic         sample_valid;
    logic         sample_right;

    int total = 0;
    int bad = 0;
    int seen = 0;
    int pushed = 0;
    bit done = 1'b0;
    bit prev_valid = 1'b0;

    logic [W:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    i2s_slave_rx #(.SAMPLE_W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .i2s_sck      (sck),
        .i2s_ws       (ws),
        .i2s_sd       (sd),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .sample_right (sample_right)
    );

    // Expected output for an n-bit word v: keep its first W bits, MSB-aligned.
    function automatic logic [W-1:0] expect_word(logic [31:0] v, int n);
        if (n >= W) return W'(v >> (n - W));
        else        return W'(v << (W - n));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bit period: select and data change while the bit clock is low.
    task automatic slot(bit w, bit d);
        @(negedge clk);
        sck = 1'b0;
        ws  = w;
        sd  = d;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    // Send an n-bit word on channel ch. The select line flips on its last bit.
    task automatic send_word(bit ch, logic [31:0] v, int n, bit record, string tag);
        if (record) begin
            exp_q.push_back({ch, expect_word(v, n)});
            tag_q.push_back(tag);
            pushed++;
        end
        for (int i = 0; i < n; i++)
            slot((i == n - 1) ? ~ch : ch, v[n-1-i]);
    endtask

    // Monitor: compare each delivered word with the next expected one.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_valid && prev_valid)
                check(1'b0, "R6", "valid wider than one cycle", 2, 1);
            if (sample_valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected word", int'(sample_data), 0);
                end else begin
                    logic [W:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(sample_data == e[W-1:0], t, "data", int'(sample_data), int'(e[W-1:0]));
                    check(sample_right == e[W], "R3", "channel", int'(sample_right), int'(e[W]));
                end
            end
            prev_valid = sample_valid;
        end
    end

    initial begin
        bit          ch;
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        check(sample_valid == 1'b0, "R1", "valid in reset", int'(sample_valid), 0);
        check(sample_data == '0, "R1", "data in reset", int'(sample_data), 0);
        check(sample_right == 1'b0, "R1", "channel in reset", int'(sample_right), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: a partial right-channel word at start-up must be dropped.
        send_word(1'b1, 32'h15, 5, 1'b0, "R7");
        repeat (4) @(negedge clk);
        check(seen == 0, "R7", "words after partial", seen, 0);
        check(sample_data == '0, "R1", "data before first word", int'(sample_data), 0);

        ch = 1'b0;
        send_word(ch, 32'h0000_A5C3, W, 1'b1, "R8");           ch = ~ch;
        send_word(ch, 32'h00F0_0FFF, W + 8, 1'b1, "R4");       ch = ~ch;
        send_word(ch, 32'h0000_000B, 4, 1'b1, "R5");           ch = ~ch;
        send_word(ch, 32'h0000_0001, 1, 1'b1, "R5");           ch = ~ch;
        send_word(ch, 32'h0000_7FFF, W - 1, 1'b1, "R5");       ch = ~ch;
        send_word(ch, 32'hDEAD_BEEF, 32, 1'b1, "R4");          ch = ~ch;
        send_word(ch, 32'h0000_8001, W, 1'b1, "R2");           ch = ~ch;

        for (int k = 0; k < 40; k++) begin
            int n;
            n = 1 + int'($urandom % 28);
            v = $urandom;
            if (n < 32) v = v & ((32'h1 << n) - 32'h1);
            send_word(ch, v, n, 1'b1, (n > W) ? "R4" : (n < W) ? "R5" : "R8");
            ch = ~ch;
        end

        // Idle with the bit clock stopped: nothing more may arrive.
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R6", "words not delivered", exp_q.size(), 0);
        check(seen == pushed, "R6", "valid pulse count", seen, pushed);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", seen, pushed);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule